// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block takes up to four asynchronous interrupt request pins from outside the chip and turns them into clean, qualified request lines for the interrupt aggregator. Each pin first passes through a two-flop synchronizer. Software then chooses, per pin, whether the request is an active-high level, an active-low level, a rising edge or a falling edge. Edge events are held in a sticky pending latch until software acknowledges them.

All configuration sits in one 32-bit control word behind a single-register write port. The word holds a per-pin enable, a per-pin two-bit sense code, a master enable for all external requests, and a routing bit for the critical request. The same word carries write-only acknowledge strobes at positions that mirror the enables. Pin 0 feeds the critical-class request line. Pins 1 to 3 feed main-class requests with source numbers 1 to 3.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0, `req_o` is all zero and `crit_route_o` is 0. Every pin is therefore disabled and set to active-high level sense.
- R2: A write stores only these fields: the enable for pin n at bit 11-n, the sense code for pin n at bits [23-2n:22-2n], the master enable at bit 12 and the routing bit at bit 0. Readback on the next cycle returns those fields. Every other bit, including the acknowledge bits [27:24], reads 0, so writing all ones reads back 32'h00FF_1F01.
- R3: `req_o[n]` is 0 whenever the enable bit of pin n is 0. All of `req_o` is 0 whenever the master enable bit 12 is 0.
- R4: With sense code 0 (active-high level), `req_o[n]` equals the pin value seen two rising clock edges earlier. A pin raised just after an edge shows on `req_o` after the second following edge and not after the first.
- R5: With sense code 3 (active-low level), `req_o[n]` is the inverse of the synchronized pin.
- R6: With sense code 1 (rising edge), a 0-to-1 transition of the synchronized pin sets a pending flag. The flag keeps `req_o[n]` at 1 after the pin returns low. A pin held high produces no new event.
- R7: With sense code 2 (falling edge), a 1-to-0 transition sets the pending flag. A 0-to-1 transition does not set it.
- R8: Writing 1 to bit 27-n clears the pending flag of pin n. Writing 0 there leaves it set. Acknowledging one pin leaves the flags of the other pins unchanged.
- R9: An edge that arrives while its pin is disabled is still recorded. It appears on `req_o[n]` once the pin is enabled.
- R10: `crit_route_o` follows control bit 0. `req_o[0]` is the critical-class request, and `req_o[3:1]` are the main-class requests for sources 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Write data for the control word, including acknowledge strobes |
| ctl_rdata | output | 32 | Current control word, with acknowledge and reserved bits reading 0 |
| ext_pin_i | input | NUM_PINS | Asynchronous external request pins |
| req_o | output | NUM_PINS | Qualified requests; bit 0 is critical-class, bits 3:1 are main sources 1 to 3 |
| crit_route_o | output | 1 | Normal-routing select for the critical request |

## Verification
The two level sense codes are driven with both pin polarities on two pins at once. This shows that the polarity is applied per pin, and a one-edge-early sample confirms the two-stage latency. The edge codes get a full pulse, a held-high pin and the transition in the opposite direction. These separate a sticky pending flag from level following and a rising detector from a falling one. Acknowledge writes with 1 and 0 in the strobe bits, and edges taken while a pin is masked or the master enable is off, show that masking gates the output but leaves capture running.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   localparam int CTRL_W    = 32;
   localparam int MAX_PINS  = 4;
   localparam int MEE_BIT   = 12;
   localparam int ROUTE_BIT = 0;

   typedef enum logic [1:0] {
      SENSE_LVL_HI = 2'd0,
      SENSE_RISE   = 2'd1,
      SENSE_FALL   = 2'd2,
      SENSE_LVL_LO = 2'd3
   } sense_e;

   function automatic int en_bit(input int n);
      return 11 - n;
   endfunction

   function automatic int ack_bit(input int n);
      return 27 - n;
   endfunction

   function automatic int sense_lsb(input int n);
      return 22 - 2 * n;
   endfunction

   // Bits that the control register stores (acknowledge strobes excluded)
   function automatic logic [CTRL_W-1:0] keep_mask(input int pins);
      logic [CTRL_W-1:0] m;
      m = '0;
      m[MEE_BIT]   = 1'b1;
      m[ROUTE_BIT] = 1'b1;
      for (int n = 0; n < pins; n++) begin
         m[en_bit(n)]        = 1'b1;
         m[sense_lsb(n)]     = 1'b1;
         m[sense_lsb(n) + 1] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [CTRL_W-1:0]         wdata_i,
   output logic [CTRL_W-1:0]         rdata_o,
   output logic [NUM_PINS-1:0]       pin_en_o,
   output logic [NUM_PINS-1:0][1:0]  pin_sense_o,
   output logic [NUM_PINS-1:0]       ack_o,
   output logic                      master_en_o,
   output logic                      route_o
);

   localparam logic [CTRL_W-1:0] KEEP = keep_mask(NUM_PINS);

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we_i) begin
         ctrl_q <= wdata_i & KEEP;
      end
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_field
      localparam int EB = en_bit(n);
      localparam int AB = ack_bit(n);
      localparam int SB = sense_lsb(n);
      assign pin_en_o[n]    = ctrl_q[EB];
      assign pin_sense_o[n] = ctrl_q[SB+1:SB];
      assign ack_o[n]       = we_i & wdata_i[AB];
   end

   assign master_en_o = ctrl_q[MEE_BIT];
   assign route_o     = ctrl_q[ROUTE_BIT];
   assign rdata_o     = ctrl_q;

endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
   import ext_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  logic [1:0] sense_i,
   input  logic       ack_i,
   input  logic       gate_i,
   output logic       req_o
);

   sense_e mode;
   logic   prev_q;
   logic   pend_q;
   logic   hit;
   logic   active;

   assign mode = sense_e'(sense_i);

   always_comb begin
      unique case (mode)
         SENSE_RISE: hit = lvl_i & ~prev_q;
         SENSE_FALL: hit = ~lvl_i & prev_q;
         default:    hit = 1'b0;
      endcase
   end

   // A fresh edge wins over an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         if (hit) begin
            pend_q <= 1'b1;
         end else if (ack_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (mode)
         SENSE_LVL_HI: active = lvl_i;
         SENSE_LVL_LO: active = ~lvl_i;
         default:      active = pend_q;
      endcase
   end

   assign req_o = gate_i & active;

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [31:0]          ctl_wdata,
   output logic [31:0]          ctl_rdata,
   input  logic [NUM_PINS-1:0]  ext_pin_i,
   output logic [NUM_PINS-1:0]  req_o,
   output logic                 crit_route_o
);

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("ext_irq_cond: NUM_PINS must lie in 1..4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_cond: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0]      pin_sync;
   logic [NUM_PINS-1:0]      pin_en;
   logic [NUM_PINS-1:0][1:0] pin_sense;
   logic [NUM_PINS-1:0]      pin_ack;
   logic                     master_en;

   ext_irq_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_pin_i),
      .q_o   (pin_sync)
   );

   ext_irq_ctrl_reg #(
      .NUM_PINS (NUM_PINS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (ctl_we),
      .wdata_i     (ctl_wdata),
      .rdata_o     (ctl_rdata),
      .pin_en_o    (pin_en),
      .pin_sense_o (pin_sense),
      .ack_o       (pin_ack),
      .master_en_o (master_en),
      .route_o     (crit_route_o)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      ext_irq_pin u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (pin_sync[n]),
         .sense_i (pin_sense[n]),
         .ack_i   (pin_ack[n]),
         .gate_i  (pin_en[n] & master_en),
         .req_o   (req_o[n])
      );
   end

endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ctl_we,
   input logic [31:0]         ctl_wdata,
   input logic [31:0]         ctl_rdata,
   input logic [NUM_PINS-1:0] req_o,
   input logic                crit_route_o
);

   localparam logic [31:0] KEEP = keep_mask(NUM_PINS);

   // R2: stored word equals written data restricted to the kept fields
   p_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> ctl_rdata == ($past(ctl_wdata) & KEEP));

   // R3: master enable off silences every request
   p_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[MEE_BIT] |-> req_o == '0);

   // R10: routing output follows the written bit
   p_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> crit_route_o == $past(ctl_wdata[ROUTE_BIT]));

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
      localparam int EB = en_bit(n);
      localparam int SB = sense_lsb(n);
      logic edge_mode;
      assign edge_mode = ctl_rdata[SB] ^ ctl_rdata[SB+1];

      // R3: disabled pin never requests
      p_pin_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !ctl_rdata[EB] |-> !req_o[n]);

      // R6: a pending edge request stays up until a write intervenes
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_o[n] && edge_mode && !ctl_we) |=> req_o[n]);
   end

endmodule

bind ext_irq_cond ext_irq_cond_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_we       (ctl_we),
   .ctl_wdata    (ctl_wdata),
   .ctl_rdata    (ctl_rdata),
   .req_o        (req_o),
   .crit_route_o (crit_route_o)
);

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic [3:0]  ext_pin_i = '0;
   logic [3:0]  req_o;
   logic        crit_route_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_cond u_ext_irq_cond (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we),
      .ctl_wdata    (ctl_wdata),
      .ctl_rdata    (ctl_rdata),
      .ext_pin_i    (ext_pin_i),
      .req_o        (req_o),
      .crit_route_o (crit_route_o)
   );

   // Build a control word: enables, sense codes (pin n at [2n+1:2n]), master, route
   function automatic logic [31:0] cfg(input logic [3:0] en, input logic [7:0] sense,
                                       input logic mee, input logic route);
      logic [31:0] w;
      w = '0;
      for (int n = 0; n < 4; n++) begin
         w[11-n]       = en[n];
         w[22-2*n]     = sense[2*n];
         w[23-2*n]     = sense[2*n+1];
      end
      w[12] = mee;
      w[0]  = route;
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      ctl_we    = 1'b1;
      ctl_wdata = d;
      @(negedge clk);
      ctl_we    = 1'b0;
      ctl_wdata = '0;
   endtask

   task automatic wait_cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 rdata", ctl_rdata, 32'h0);
      chk("R1 req", {28'h0, req_o}, 32'h0);
      chk("R1 route", {31'h0, crit_route_o}, 32'h0);
   endtask

   task automatic t_regs;
      wr(32'hFFFF_FFFF);
      chk("R2 all ones readback", ctl_rdata, 32'h00FF_1F01);
      wr(cfg(4'b0101, 8'b11_10_01_00, 1'b1, 1'b0));
      chk("R2 field placement", ctl_rdata, 32'h001B_1A00);
      wr(32'h0);
      chk("R2 cleared", ctl_rdata, 32'h0);
   endtask

   task automatic t_level;
      // pin0 active-high, pin1 active-low, all enabled
      wr(cfg(4'b0011, 8'b00_00_11_00, 1'b1, 1'b0));
      wait_cyc(3);
      chk("R5 low-active idle", {28'h0, req_o}, 32'h2);
      ext_pin_i[0] = 1'b1;
      @(negedge clk);
      chk("R4 not yet after one edge", {31'h0, req_o[0]}, 32'h0);
      @(negedge clk);
      chk("R4 after two edges / R10 critical line", {31'h0, req_o[0]}, 32'h1);
      ext_pin_i[1] = 1'b1;
      wait_cyc(3);
      chk("R5 low-active pin high", {31'h0, req_o[1]}, 32'h0);
      ext_pin_i[0] = 1'b0;
      wait_cyc(3);
      chk("R4 follows pin low", {31'h0, req_o[0]}, 32'h0);
      ext_pin_i[1] = 1'b0;
      wait_cyc(3);
   endtask

   task automatic t_mask;
      ext_pin_i[0] = 1'b1;
      wr(cfg(4'b0001, 8'h00, 1'b0, 1'b0));
      wait_cyc(3);
      chk("R3 master off", {28'h0, req_o}, 32'h0);
      wr(cfg(4'b0000, 8'h00, 1'b1, 1'b0));
      chk("R3 pin disabled", {28'h0, req_o}, 32'h0);
      wr(cfg(4'b0001, 8'h00, 1'b1, 1'b0));
      chk("R3 pin enabled", {28'h0, req_o}, 32'h1);
      ext_pin_i[0] = 1'b0;
      wait_cyc(3);
   endtask

   task automatic t_rise;
      // pin2 rising, pin3 falling
      wr(cfg(4'b1100, 8'b10_01_00_00, 1'b1, 1'b0));
      wait_cyc(2);
      chk("R6 no event yet", {28'h0, req_o}, 32'h0);
      ext_pin_i[2] = 1'b1;
      wait_cyc(4);
      chk("R6 rise seen", {31'h0, req_o[2]}, 32'h1);
      ext_pin_i[2] = 1'b0;
      wait_cyc(4);
      chk("R6 sticky after pin low", {31'h0, req_o[2]}, 32'h1);
      ext_pin_i[3] = 1'b1;
      wait_cyc(4);
      chk("R7 rise ignored on falling pin", {31'h0, req_o[3]}, 32'h0);
      ext_pin_i[3] = 1'b0;
      wait_cyc(4);
      chk("R7 fall seen", {31'h0, req_o[3]}, 32'h1);
   endtask

   task automatic t_ack;
      logic [31:0] base;
      base = cfg(4'b1100, 8'b10_01_00_00, 1'b1, 1'b0);
      wr(base | 32'h0200_0000);
      chk("R8 ack pin2 clears it only", {28'h0, req_o}, 32'h8);
      wr(base);
      chk("R8 zero ack keeps pin3", {28'h0, req_o}, 32'h8);
      wr(base | 32'h0100_0000);
      chk("R8 ack pin3", {28'h0, req_o}, 32'h0);
      chk("R2 ack bits read 0", ctl_rdata, base);
      ext_pin_i[2] = 1'b1;
      wait_cyc(4);
      wr(base | 32'h0200_0000);
      wait_cyc(4);
      chk("R6 held-high pin makes no new event", {31'h0, req_o[2]}, 32'h0);
      ext_pin_i[2] = 1'b0;
      wait_cyc(3);
   endtask

   task automatic t_masked_edge;
      logic [31:0] base;
      base = cfg(4'b0000, 8'b10_01_00_00, 1'b1, 1'b0);
      wr(base);
      ext_pin_i[2] = 1'b1;
      wait_cyc(4);
      ext_pin_i[2] = 1'b0;
      wait_cyc(4);
      chk("R9 masked edge hidden", {28'h0, req_o}, 32'h0);
      wr(cfg(4'b0100, 8'b10_01_00_00, 1'b1, 1'b0));
      chk("R9 edge shows on enable", {28'h0, req_o}, 32'h4);
      wr(cfg(4'b0100, 8'b10_01_00_00, 1'b1, 1'b0) | 32'h0200_0000);
      chk("R8 cleared after enable", {28'h0, req_o}, 32'h0);
   endtask

   task automatic t_route;
      wr(cfg(4'b0000, 8'h00, 1'b0, 1'b1));
      chk("R10 route set", {31'h0, crit_route_o}, 32'h1);
      wr(cfg(4'b0000, 8'h00, 1'b0, 1'b0));
      chk("R10 route clear", {31'h0, crit_route_o}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      wait_cyc(4);
      t_reset;
      rst_n = 1'b1;
      wait_cyc(1);
      t_reset;
      t_regs;
      t_level;
      t_mask;
      t_rise;
      t_ack;
      t_masked_edge;
      t_route;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule